// File: doc/BRIEF.md
# Parallel NOR Command Sequencer

This block sits between a host and the bus of a parallel NOR flash. The host raises a one-cycle request carrying an opcode, a target address and a data word. The block then plays out the fixed list of address/data write cycles that the flash needs in order to recognise that command. For identification and query commands it also issues read cycles and hands each returned word back to the host.

Each command is a short script. Program, erase and identification scripts start with a two-write unlock prefix. Erase scripts add a second unlock before the cycle that picks the erase type. A configuration input selects byte-wide addressing, which doubles every command and offset address.

Strobe timing on the pins, completion polling and buffered programming belong to neighbouring logic. The block drives one-cycle write and read strobes on a synchronous bus. Read data returns in the cycle after the read strobe.

Top module: `nor_cmd_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `busy`, `ack`, `reject`, `done`, `res_valid`, `fl_we` and `fl_re` are all low.
- R2: A legal request taken while idle gives a one-cycle `ack` in the next cycle, and `busy` rises in that same cycle. Opcodes are 0 return-to-read, 1 identify, 2 word program, 3 sector erase, 4 chip erase and 5 query.
- R3: Identify, program and both erase scripts begin with data 0xAA at command address 0x555, then data 0x55 at command address 0x2AA.
- R4: Identify continues with 0x90 at 0x555, then reads offsets 0x00, 0x01, 0x0E and 0x0F in that order. It returns the four words in the same order.
- R5: Program continues with 0xA0 at 0x555, then writes the request data to the request address.
- R6: Both erase scripts continue with 0x80 at 0x555, 0xAA at 0x555 and 0x55 at 0x2AA. Sector erase ends with 0x30 at the request address. Chip erase ends with 0x10 at 0x555.
- R7: Query writes 0x98 at 0x055, then reads offsets 0x10, 0x11 and 0x12 and returns those words in order.
- R8: Return-to-read is a single write of 0xF0 to address 0.
- R9: When `byte_mode` is high, every command and read-offset address is shifted left by one bit. The request address is always driven unshifted.
- R10: A request that arrives while an operation is running gets a one-cycle `reject` and does not alter the running script.
- R11: Opcodes 6 and 7 are rejected with a one-cycle `reject`, with no bus cycle and no `done`.
- R12: While `wr_protect` is high, program and erase requests are rejected and produce no bus cycle. Return-to-read, identify and query requests are still accepted.
- R13: `done` pulses for one cycle and `busy` falls in that same cycle. The pulse comes one cycle after the last write strobe, or one cycle after the last returned word when the script ends with a read.
- R14: Each strobe is high for exactly one cycle per bus cycle, and `fl_we` and `fl_re` are never high together. The word read by a strobe appears on `res_data` with `res_valid` two cycles after that strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | One-cycle request strobe |
| req_op | input | 3 | Opcode of the request |
| req_addr | input | AW | Target address (program data or sector address) |
| req_data | input | DW | Data word for program |
| byte_mode | input | 1 | High for a byte-wide device (command addresses doubled) |
| wr_protect | input | 1 | High blocks program and erase requests |
| ack | output | 1 | Request accepted (one cycle) |
| reject | output | 1 | Request refused (one cycle) |
| busy | output | 1 | A script is in progress |
| done | output | 1 | Script finished (one cycle) |
| res_valid | output | 1 | A read word is on `res_data` |
| res_data | output | DW | Word returned by a read cycle |
| fl_addr | output | AW | Flash bus address |
| fl_wdata | output | DW | Flash bus write data |
| fl_we | output | 1 | Flash write strobe |
| fl_re | output | 1 | Flash read strobe |
| fl_rdata | input | DW | Flash read data, valid the cycle after `fl_re` |

## Verification
A wrong step counter or script entry shows up at the bus as a wrong address/data pair, or as a wrong number of strobes before `done`. The bench compares every strobe of every script against an expected list, so such a fault is reported within the command in which it occurs. A fault in the acceptance or drain state shows as a missing `ack` or `reject` in the cycle right after the request, or as `done` in the wrong cycle relative to the last strobe or returned word. Faults in the read capture path show as a wrong word, or a word in the wrong cycle, two cycles after a read strobe.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  typedef enum logic [2:0] {
    OP_RESET = 3'd0,
    OP_IDENT = 3'd1,
    OP_PROG  = 3'd2,
    OP_SECT  = 3'd3,
    OP_CHIP  = 3'd4,
    OP_QUERY = 3'd5
  } op_e;

  // how a step forms its address
  typedef enum logic [1:0] {
    ST_CMD,   // scaled command address, constant data
    ST_USR,   // request address, unscaled
    ST_RD,    // scaled offset, read cycle
    ST_BASE   // device base (address 0)
  } kind_e;

  typedef struct packed {
    kind_e       kind;
    logic [11:0] ofs;
    logic [7:0]  cval;
    logic        udata;
    logic        last;
  } step_t;

  localparam int MAX_STEPS = 7;
  localparam int STEP_W    = $clog2(MAX_STEPS);

  function automatic logic op_legal(input logic [2:0] op);
    return op <= 3'd5;
  endfunction

  function automatic logic op_alters(input logic [2:0] op);
    return (op == OP_PROG) || (op == OP_SECT) || (op == OP_CHIP);
  endfunction

  function automatic step_t mk(input kind_e k, input logic [11:0] o,
                               input logic [7:0] c, input logic u, input logic l);
    step_t s;
    s.kind  = k;
    s.ofs   = o;
    s.cval  = c;
    s.udata = u;
    s.last  = l;
    return s;
  endfunction

endpackage

// File: rtl/nor_seq_script.sv
module nor_seq_script
  import nor_seq_pkg::*;
#(
  parameter int IDX_W = STEP_W
) (
  input  logic [2:0]       op,
  input  logic [IDX_W-1:0] idx,
  output step_t            step
);

  always_comb begin
    step = mk(ST_BASE, 12'h000, 8'hF0, 1'b0, 1'b1);
    case (op_e'(op))
      OP_RESET: step = mk(ST_BASE, 12'h000, 8'hF0, 1'b0, 1'b1);
      OP_QUERY: begin
        case (idx)
          0:       step = mk(ST_CMD, 12'h055, 8'h98, 1'b0, 1'b0);
          1:       step = mk(ST_RD,  12'h010, 8'h00, 1'b0, 1'b0);
          2:       step = mk(ST_RD,  12'h011, 8'h00, 1'b0, 1'b0);
          default: step = mk(ST_RD,  12'h012, 8'h00, 1'b0, 1'b1);
        endcase
      end
      OP_IDENT, OP_PROG, OP_SECT, OP_CHIP: begin
        if (idx == 0)
          step = mk(ST_CMD, 12'h555, 8'hAA, 1'b0, 1'b0);
        else if (idx == 1)
          step = mk(ST_CMD, 12'h2AA, 8'h55, 1'b0, 1'b0);
        else if (op == OP_IDENT) begin
          case (idx)
            2:       step = mk(ST_CMD, 12'h555, 8'h90, 1'b0, 1'b0);
            3:       step = mk(ST_RD,  12'h000, 8'h00, 1'b0, 1'b0);
            4:       step = mk(ST_RD,  12'h001, 8'h00, 1'b0, 1'b0);
            5:       step = mk(ST_RD,  12'h00E, 8'h00, 1'b0, 1'b0);
            default: step = mk(ST_RD,  12'h00F, 8'h00, 1'b0, 1'b1);
          endcase
        end else if (op == OP_PROG) begin
          if (idx == 2) step = mk(ST_CMD, 12'h555, 8'hA0, 1'b0, 1'b0);
          else          step = mk(ST_USR, 12'h000, 8'h00, 1'b1, 1'b1);
        end else begin
          case (idx)
            2: step = mk(ST_CMD, 12'h555, 8'h80, 1'b0, 1'b0);
            3: step = mk(ST_CMD, 12'h555, 8'hAA, 1'b0, 1'b0);
            4: step = mk(ST_CMD, 12'h2AA, 8'h55, 1'b0, 1'b0);
            default: begin
              if (op == OP_SECT) step = mk(ST_USR, 12'h000, 8'h30, 1'b0, 1'b1);
              else               step = mk(ST_CMD, 12'h555, 8'h10, 1'b0, 1'b1);
            end
          endcase
        end
      end
      default: step = mk(ST_BASE, 12'h000, 8'hF0, 1'b0, 1'b1);
    endcase
  end

endmodule

// File: rtl/nor_seq_addr.sv
module nor_seq_addr
  import nor_seq_pkg::*;
#(
  parameter int AW           = 20,
  parameter int DW           = 16,
  parameter bit BYTE_CAPABLE = 1'b1
) (
  input  kind_e         kind,
  input  logic [11:0]   ofs,
  input  logic [7:0]    cval,
  input  logic          use_udata,
  input  logic [AW-1:0] uaddr,
  input  logic [DW-1:0] uword,
  input  logic          byte_mode,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] wdata
);

  logic [AW-1:0] ofs_w;
  logic [AW-1:0] scaled;

  assign ofs_w = AW'(ofs);

  generate
    if (BYTE_CAPABLE) begin : g_byte
      assign scaled = byte_mode ? (ofs_w << 1) : ofs_w;
    end else begin : g_word
      logic unused_bm;
      assign unused_bm = byte_mode;
      assign scaled    = ofs_w;
    end
  endgenerate

  always_comb begin
    case (kind)
      ST_CMD, ST_RD: addr = scaled;
      ST_USR:        addr = uaddr;
      default:       addr = '0;
    endcase
    if (kind == ST_RD)  wdata = '0;
    else if (use_udata) wdata = uword;
    else                wdata = DW'(cval);
  end

endmodule

// File: rtl/nor_seq_capture.sv
module nor_seq_capture #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          strobe,
  input  logic [DW-1:0] rdata,
  output logic          pending,
  output logic          valid,
  output logic [DW-1:0] data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      valid   <= 1'b0;
      data    <= '0;
    end else begin
      pending <= strobe;
      valid   <= pending;
      if (pending) data <= rdata;
    end
  end

  // R14
  rv_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    valid |-> $past(strobe, 2));

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int AW           = 20,
  parameter int DW           = 16,
  parameter bit BYTE_CAPABLE = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic [2:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic          byte_mode,
  input  logic          wr_protect,
  output logic          ack,
  output logic          reject,
  output logic          busy,
  output logic          done,
  output logic          res_valid,
  output logic [DW-1:0] res_data,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_wdata,
  output logic          fl_we,
  output logic          fl_re,
  input  logic [DW-1:0] fl_rdata
);

  localparam int IDX_W = STEP_W;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DRAIN} st_e;

  st_e              st;
  logic [2:0]       op_q;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    data_q;
  logic             bm_q;
  logic [IDX_W-1:0] idx_q;
  step_t            cur;
  logic [AW-1:0]    nx_addr;
  logic [DW-1:0]    nx_wdata;
  logic             rd_pend;
  logic             go_ok;

  nor_seq_script #(.IDX_W(IDX_W)) u_script (
    .op  (op_q),
    .idx (idx_q),
    .step(cur)
  );

  nor_seq_addr #(.AW(AW), .DW(DW), .BYTE_CAPABLE(BYTE_CAPABLE)) u_map (
    .kind     (cur.kind),
    .ofs      (cur.ofs),
    .cval     (cur.cval),
    .use_udata(cur.udata),
    .uaddr    (addr_q),
    .uword    (data_q),
    .byte_mode(bm_q),
    .addr     (nx_addr),
    .wdata    (nx_wdata)
  );

  nor_seq_capture #(.DW(DW)) u_cap (
    .clk    (clk),
    .rst    (rst),
    .strobe (fl_re),
    .rdata  (fl_rdata),
    .pending(rd_pend),
    .valid  (res_valid),
    .data   (res_data)
  );

  assign go_ok = op_legal(req_op) && !(wr_protect && op_alters(req_op));

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      op_q     <= '0;
      addr_q   <= '0;
      data_q   <= '0;
      bm_q     <= 1'b0;
      idx_q    <= '0;
      ack      <= 1'b0;
      reject   <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      fl_addr  <= '0;
      fl_wdata <= '0;
      fl_we    <= 1'b0;
      fl_re    <= 1'b0;
    end else begin
      ack    <= 1'b0;
      reject <= 1'b0;
      done   <= 1'b0;
      fl_we  <= 1'b0;
      fl_re  <= 1'b0;
      case (st)
        S_IDLE: begin
          if (req) begin
            if (go_ok) begin
              ack    <= 1'b1;
              busy   <= 1'b1;
              st     <= S_RUN;
              idx_q  <= '0;
              op_q   <= req_op;
              addr_q <= req_addr;
              data_q <= req_data;
              bm_q   <= byte_mode;
            end else begin
              reject <= 1'b1;
            end
          end
        end
        S_RUN: begin
          if (req) reject <= 1'b1;
          fl_we    <= (cur.kind != ST_RD);
          fl_re    <= (cur.kind == ST_RD);
          fl_addr  <= nx_addr;
          fl_wdata <= nx_wdata;
          idx_q    <= idx_q + 1'b1;
          if (cur.last) st <= S_DRAIN;
        end
        default: begin
          if (req) reject <= 1'b1;
          if (!fl_re && !rd_pend) begin
            done <= 1'b1;
            busy <= 1'b0;
            st   <= S_IDLE;
          end
        end
      endcase
    end
  end

  // R14
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(fl_we && fl_re));

  // R13
  strobe_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (fl_we || fl_re) |-> busy);

  // R13
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  // R2
  ack_with_busy_chk: assert property (@(posedge clk) disable iff (rst)
    ack |-> (busy && !$past(busy)));

  // R10
  ack_rej_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(ack && reject));

  // R10
  busy_req_rej_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !done && req) |=> reject);

endmodule

// File: tb/tb_nor_cmd_seq.sv
`timescale 1ns/1ps
module tb_nor_cmd_seq;
  localparam int AW = 20;
  localparam int DW = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst;
  logic          req;
  logic [2:0]    req_op;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_data;
  logic          byte_mode, wr_protect;
  logic          ack, reject, busy, done, res_valid;
  logic [DW-1:0] res_data;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] fl_wdata;
  logic          fl_we, fl_re;
  logic [DW-1:0] fl_rdata;

  nor_cmd_seq #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rst(rst), .req(req), .req_op(req_op), .req_addr(req_addr),
    .req_data(req_data), .byte_mode(byte_mode), .wr_protect(wr_protect),
    .ack(ack), .reject(reject), .busy(busy), .done(done),
    .res_valid(res_valid), .res_data(res_data), .fl_addr(fl_addr),
    .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_re(fl_re), .fl_rdata(fl_rdata)
  );

  function automatic logic [DW-1:0] fmodel(input logic [AW-1:0] a);
    return (a[15:0] * 16'd7) ^ 16'h5A3C;
  endfunction

  logic [DW-1:0] rd_q = '0;
  always @(posedge clk) if (fl_re) rd_q <= fmodel(fl_addr);
  assign fl_rdata = rd_q;

  int cyc = 0;
  always @(posedge clk) cyc++;

  int total = 0;
  int bad = 0;

  // bus and result log
  int            ev_n = 0;
  bit            ev_rd [16];
  logic [AW-1:0] ev_a  [16];
  logic [DW-1:0] ev_d  [16];
  int            ev_c  [16];
  int            rs_n = 0;
  logic [DW-1:0] rs_d  [8];
  int            rs_c  [8];
  int            dn_n = 0;
  int            dn_c = 0;
  bit            both_seen = 0;
  bit            wide_strobe = 0;

  always @(negedge clk) begin
    if (fl_we && fl_re) both_seen = 1;
    if (fl_we || fl_re) begin
      if (ev_n > 0 && ev_n <= 16 && ev_c[ev_n-1] == cyc - 1 && ev_a[ev_n-1] == fl_addr
          && ev_rd[ev_n-1] == fl_re && ev_d[ev_n-1] == fl_wdata && fl_re)
        wide_strobe = 1;
      if (ev_n < 16) begin
        ev_rd[ev_n] = fl_re;
        ev_a[ev_n]  = fl_addr;
        ev_d[ev_n]  = fl_wdata;
        ev_c[ev_n]  = cyc;
      end
      ev_n++;
    end
    if (res_valid) begin
      if (rs_n < 8) begin
        rs_d[rs_n] = res_data;
        rs_c[rs_n] = cyc;
      end
      rs_n++;
    end
    if (done) begin
      dn_n++;
      dn_c = cyc;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic int exp_len(input int op);
    case (op)
      0: return 1;
      1: return 7;
      2: return 4;
      5: return 4;
      default: return 6;
    endcase
  endfunction

  function automatic logic [AW-1:0] sc(input int x, input bit bm);
    return bm ? AW'(x * 2) : AW'(x);
  endfunction

  // {rd, addr, data}
  function automatic logic [AW+DW:0] exp_step(input int op, input int i, input bit bm,
                                              input logic [AW-1:0] ua, input logic [DW-1:0] ud);
    bit rd;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    rd = 0; a = '0; d = '0;
    if (op == 0) begin
      d = 16'h00F0;
    end else if (op == 5) begin
      if (i == 0) begin a = sc(16'h055, bm); d = 16'h0098; end
      else begin rd = 1; a = sc(15 + i, bm); end
    end else if (i == 0) begin
      a = sc(16'h555, bm); d = 16'h00AA;
    end else if (i == 1) begin
      a = sc(16'h2AA, bm); d = 16'h0055;
    end else if (op == 1) begin
      if (i == 2) begin a = sc(16'h555, bm); d = 16'h0090; end
      else begin
        rd = 1;
        case (i)
          3: a = sc(0, bm);
          4: a = sc(1, bm);
          5: a = sc(14, bm);
          default: a = sc(15, bm);
        endcase
      end
    end else if (op == 2) begin
      if (i == 2) begin a = sc(16'h555, bm); d = 16'h00A0; end
      else begin a = ua; d = ud; end
    end else begin
      case (i)
        2: begin a = sc(16'h555, bm); d = 16'h0080; end
        3: begin a = sc(16'h555, bm); d = 16'h00AA; end
        4: begin a = sc(16'h2AA, bm); d = 16'h0055; end
        default: begin
          if (op == 3) begin a = ua; d = 16'h0030; end
          else begin a = sc(16'h555, bm); d = 16'h0010; end
        end
      endcase
    end
    return {rd, a, d};
  endfunction

  function automatic string op_tag(input int op, input bit bm);
    if (bm) return "R9";
    case (op)
      0: return "R8";
      1: return "R4";
      2: return "R5";
      5: return "R7";
      default: return "R6";
    endcase
  endfunction

  task automatic run_op(input int op, input logic [AW-1:0] ua, input logic [DW-1:0] ud,
                        input bit bm, input bit prot, input bit intrude);
    bit accept;
    bit got;
    int nrd;
    int lst;
    logic [AW+DW:0] e;
    string tg;
    accept = (op < 6) && !(prot && (op == 2 || op == 3 || op == 4));
    @(negedge clk);
    ev_n = 0; rs_n = 0; dn_n = 0;
    req = 1; req_op = 3'(op); req_addr = ua; req_data = ud;
    byte_mode = bm; wr_protect = prot;
    @(negedge clk);
    req = 0;
    req_op = 3'($urandom % 8); req_addr = AW'($urandom); req_data = DW'($urandom);
    if (!accept) begin
      chk(reject == 1'b1, op > 5 ? "R11" : "R12", "reject pulse", 32'(reject), 1);
      chk(ack == 1'b0, op > 5 ? "R11" : "R12", "no ack", 32'(ack), 0);
      repeat (5) @(negedge clk);
      chk(ev_n == 0 && dn_n == 0 && busy == 1'b0, op > 5 ? "R11" : "R12",
          "no bus activity", 32'(ev_n + dn_n), 0);
      return;
    end
    chk(ack == 1'b1 && reject == 1'b0, "R2", "ack after request", 32'(ack), 1);
    chk(busy == 1'b1, "R2", "busy with ack", 32'(busy), 1);
    if (prot) chk(ack == 1'b1, "R12", "read-type op allowed under protect", 32'(ack), 1);
    if (intrude) begin
      req = 1; req_op = 3'd2;
      @(negedge clk);
      req = 0;
      chk(reject == 1'b1, "R10", "reject while busy", 32'(reject), 1);
    end
    got = 0;
    for (int k = 0; k < 60; k++) begin
      if (done) begin got = 1; break; end
      @(negedge clk);
    end
    chk(got, "R13", "done seen", 32'(got), 1);
    chk(busy == 1'b0, "R13", "busy low at done", 32'(busy), 0);
    @(negedge clk);
    chk(done == 1'b0 && dn_n == 1, "R13", "done one cycle", 32'(dn_n), 1);
    chk(ev_n == exp_len(op), op_tag(op, bm), "bus cycle count", 32'(ev_n), 32'(exp_len(op)));
    nrd = 0;
    if (ev_n == exp_len(op)) begin
      for (int i = 0; i < ev_n; i++) begin
        e = exp_step(op, i, bm, ua, ud);
        tg = (i < 2 && op >= 1 && op <= 4 && !bm) ? "R3" : op_tag(op, bm);
        chk(ev_rd[i] == e[AW+DW], tg, "cycle kind", 32'(ev_rd[i]), 32'(e[AW+DW]));
        chk(ev_a[i] == e[AW+DW-1:DW], tg, "cycle address", 32'(ev_a[i]), 32'(e[AW+DW-1:DW]));
        if (!e[AW+DW])
          chk(ev_d[i] == e[DW-1:0], tg, "cycle data", 32'(ev_d[i]), 32'(e[DW-1:0]));
        else begin
          if (nrd < rs_n && nrd < 8) begin
            chk(rs_d[nrd] == fmodel(e[AW+DW-1:DW]), op_tag(op, bm), "returned word",
                32'(rs_d[nrd]), 32'(fmodel(e[AW+DW-1:DW])));
            chk(rs_c[nrd] == ev_c[i] + 2, "R14", "read latency",
                32'(rs_c[nrd]), 32'(ev_c[i] + 2));
          end
          nrd++;
        end
      end
      chk(rs_n == nrd, op_tag(op, bm), "returned word count", 32'(rs_n), 32'(nrd));
      lst = ev_n - 1;
      if (nrd == 0)
        chk(dn_c == ev_c[lst] + 1, "R13", "done after last write", 32'(dn_c), 32'(ev_c[lst] + 1));
      else if (rs_n > 0 && rs_n <= 8)
        chk(dn_c == rs_c[rs_n-1] + 1, "R13", "done after last word",
            32'(dn_c), 32'(rs_c[rs_n-1] + 1));
    end
  endtask

  task automatic finish_run();
    chk(!both_seen && !wide_strobe, "R14", "strobes single and exclusive", 32'(both_seen), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R13 watchdog expired actual=%0h expected=%0h", cyc, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1; req = 0; req_op = '0; req_addr = '0; req_data = '0;
    byte_mode = 0; wr_protect = 0;
    repeat (3) @(negedge clk);
    chk(busy == 0 && ack == 0 && reject == 0 && done == 0 && res_valid == 0 &&
        fl_we == 0 && fl_re == 0, "R1", "outputs during reset", 32'(busy), 0);
    rst = 0;
    @(negedge clk);
    chk(busy == 0 && ack == 0 && reject == 0 && done == 0 && res_valid == 0 &&
        fl_we == 0 && fl_re == 0, "R1", "outputs after reset", 32'(busy), 0);

    run_op(0, 20'h12345, 16'h1111, 0, 0, 0);   // R8
    run_op(1, 20'h0, 16'h0, 0, 0, 0);          // R3 R4
    run_op(1, 20'h0, 16'h0, 1, 0, 0);          // R9
    run_op(2, 20'h0ABCD, 16'hBEEF, 0, 0, 0);   // R5
    run_op(2, 20'h0ABCD, 16'hCAFE, 1, 0, 0);   // R9 user address unshifted
    run_op(3, 20'h40000, 16'h0, 0, 0, 0);      // R6 sector
    run_op(4, 20'h0, 16'h0, 0, 0, 0);          // R6 chip
    run_op(4, 20'h0, 16'h0, 1, 0, 0);          // R9
    run_op(5, 20'h0, 16'h0, 0, 0, 0);          // R7
    run_op(5, 20'h0, 16'h0, 1, 0, 0);          // R9
    run_op(2, 20'h00010, 16'h1234, 0, 1, 0);   // R12 blocked
    run_op(3, 20'h20000, 16'h0, 0, 1, 0);      // R12 blocked
    run_op(4, 20'h0, 16'h0, 1, 1, 0);          // R12 blocked
    run_op(1, 20'h0, 16'h0, 0, 1, 0);          // R12 allowed
    run_op(5, 20'h0, 16'h0, 0, 1, 0);          // R12 allowed
    run_op(6, 20'h0, 16'h0, 0, 0, 0);          // R11
    run_op(7, 20'h0, 16'h0, 0, 0, 0);          // R11
    run_op(4, 20'h0, 16'h0, 0, 0, 1);          // R10
    run_op(1, 20'h0, 16'h0, 1, 0, 1);          // R10 during reads

    for (int n = 0; n < 40; n++) begin
      int op;
      logic [31:0] ra, rd;
      op = int'($urandom % 8);
      ra = $urandom;
      rd = $urandom;
      run_op(op, ra[AW-1:0], rd[DW-1:0], 1'($urandom % 2), ($urandom % 4) == 0, 0);
    end
    finish_run();
  end

endmodule